// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the sharer directory placed next to a shared second-level cache. It records, for each cached line, which of up to six cores hold a copy, and keeps their private caches coherent. Every core has its own point-to-point request channel and its own invalidate channel with an acknowledge. There is no wiring between cores. The directory contacts only the cores that its records list for a line. It never broadcasts to every core.

A core asks for a line with `req_valid` and holds the request until `resp_valid` returns for it. `req_write` chooses between a shared read and an exclusive write or upgrade. For a write, the directory invalidates every other sharer and waits for each acknowledge. It then grants exclusive ownership and records the writer as the only holder. A read of a line that another core holds Modified first downgrades that owner. The tracking store is direct-mapped. A request that maps onto an index held by a different line first back-invalidates every holder of the old line. The controller serves one transaction at a time. Simultaneous requests are taken in round-robin core order.

Top module: `dir_coherence`

## Requirements
- R1: After reset, `resp_valid` and `inv_valid` are all zero until a request arrives.
- R2: A read of a line that no other core holds Modified receives `resp_excl`=0 and sends no invalidate. The requester is recorded as a sharer.
- R3: A write raises `inv_valid` for exactly the recorded sharers other than the requester. It uses `inv_kind`=0 (invalidate) and `inv_addr` equal to the requested line address.
- R4: The grant for a write carries `resp_excl`=1 and appears only after every targeted core has acknowledged. Reads reply with `resp_excl`=0.
- R5: A read of a line held Modified by another core sends `inv_kind`=1 (downgrade) to that owner only. The reply comes after its acknowledge. Afterwards both owner and requester are recorded as sharers.
- R6: A write by the core that already holds the line Modified is granted without any invalidate.
- R7: Only one transaction is in flight. A request arriving during another's invalidate phase gets no response until that transaction completes.
- R8: Pending requests are served in round-robin order, starting from the core after the last one served.
- R9: The line address is split into a low index of log2(SETS) bits and a tag. A request whose index holds a different valid line first invalidates (`inv_kind`=0) all holders of that line, with `inv_addr` set to the old line address.
- R10: Each `inv_valid` bit stays high until that core pulses `inv_ack`, then drops. `inv_addr` stays stable while any bit is high.
- R11: `resp_valid` is one-hot, lasts one cycle, and goes only to the core whose request is being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCORE | Per-core request, held until answered |
| req_write | input | NCORE | Per-core: 1 write/upgrade, 0 shared read |
| req_addr | input | NCORE*ADDR_W | Per-core line address, core c at bits c*ADDR_W |
| resp_valid | output | NCORE | Per-core one-cycle completion |
| resp_excl | output | 1 | 1 when the completion grants exclusive ownership |
| inv_valid | output | NCORE | Per-core invalidate or downgrade, held until acked |
| inv_kind | output | 1 | 0 invalidate, 1 downgrade to shared |
| inv_addr | output | ADDR_W | Line address of the invalidate |
| inv_ack | input | NCORE | Per-core one-cycle acknowledge |

## Verification
The hardest situation to reach from the ports is a second request arriving while the first one is stuck in its acknowledge wait. The bench freezes the model cores' acknowledges, raises a write that needs an invalidate, and then adds a read from another core. It watches both stay unanswered until the acknowledges are released. The replacement back-invalidate is reached by steering a later request onto an index already held by a Modified line under another tag. A recall is reached by reading a line just after another core's write.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_CHECK = 2'd1,
    F_WAIT  = 2'd2,
    F_DONE  = 2'd3
  } fsm_e;
endpackage

// File: rtl/dir_rr_arb.sv
module dir_rr_arb #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] last_q;

  always_comb begin
    any     = 1'b0;
    gnt_idx = '0;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = (int'(last_q) + off) % N;
      if (!any && req[cand]) begin
        any     = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (take) last_q <= gnt_idx;
  end
endmodule

// File: rtl/dir_array.sv
module dir_array
  import dir_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  parameter int N     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_e         rd_st,
  output logic [N-1:0]     rd_vec,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st,
  input  logic [N-1:0]     wr_vec
);
  logic [TAG_W-1:0] tag_q [SETS];
  line_st_e         st_q  [SETS];
  logic [N-1:0]     vec_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic hit_w;
    assign hit_w = we && (wr_idx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[s] <= '0;
        st_q[s]  <= LS_INV;
        vec_q[s] <= '0;
      end else if (hit_w) begin
        tag_q[s] <= wr_tag;
        st_q[s]  <= wr_st;
        vec_q[s] <= wr_vec;
      end
    end
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_st  = st_q[rd_idx];
  assign rd_vec = vec_q[rd_idx];
endmodule

// File: rtl/dir_coherence.sv
module dir_coherence
  import dir_pkg::*;
#(
  parameter int NCORE  = 6,
  parameter int ADDR_W = 12,
  parameter int SETS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCORE-1:0]        req_valid,
  input  logic [NCORE-1:0]        req_write,
  input  logic [NCORE*ADDR_W-1:0] req_addr,
  output logic [NCORE-1:0]        resp_valid,
  output logic                    resp_excl,
  output logic [NCORE-1:0]        inv_valid,
  output logic                    inv_kind,
  output logic [ADDR_W-1:0]       inv_addr,
  input  logic [NCORE-1:0]        inv_ack
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CID_W = (NCORE > 1) ? $clog2(NCORE) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  fsm_e              fsm_q, fsm_d;
  logic [CID_W-1:0]  cur_q, cur_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NCORE-1:0]  pend_q, pend_d;
  logic              kind_q, kind_d;
  logic [ADDR_W-1:0] iaddr_q, iaddr_d;
  logic              evict_q, evict_d;
  logic [NCORE-1:0]  cur_oh;

  logic [CID_W-1:0]  gnt_idx;
  logic              any, take;

  logic [TAG_W-1:0]  e_tag;
  line_st_e          e_st;
  logic [NCORE-1:0]  e_vec;
  logic              tbl_we;
  line_st_e          w_st;
  logic [NCORE-1:0]  w_vec;

  logic              tag_hit;
  line_st_e          h_st;
  logic [NCORE-1:0]  h_vec;

  dir_rr_arb #(.N(NCORE), .IW(CID_W)) u_arb (
    .clk(clk), .rst_n(rst_l), .req(req_valid), .take(take),
    .gnt_idx(gnt_idx), .any(any)
  );

  dir_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .N(NCORE)) u_tbl (
    .clk(clk), .rst_n(rst_l),
    .rd_idx(addr_q[IDX_W-1:0]), .rd_tag(e_tag), .rd_st(e_st), .rd_vec(e_vec),
    .we(tbl_we), .wr_idx(addr_q[IDX_W-1:0]), .wr_tag(addr_q[ADDR_W-1:IDX_W]),
    .wr_st(w_st), .wr_vec(w_vec)
  );

  assign cur_oh  = NCORE'(1) << cur_q;
  assign tag_hit = (e_st == LS_INV) || (e_tag == addr_q[ADDR_W-1:IDX_W]);
  assign h_st    = tag_hit ? e_st : LS_INV;
  assign h_vec   = (tag_hit && e_st != LS_INV) ? e_vec : '0;

  // next-state logic
  always_comb begin
    fsm_d   = fsm_q;
    cur_d   = cur_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    pend_d  = pend_q;
    kind_d  = kind_q;
    iaddr_d = iaddr_q;
    evict_d = evict_q;
    take    = 1'b0;
    tbl_we  = 1'b0;
    w_st    = LS_INV;
    w_vec   = '0;
    case (fsm_q)
      F_IDLE: begin
        if (any) begin
          take   = 1'b1;
          cur_d  = gnt_idx;
          wr_d   = req_write[gnt_idx];
          addr_d = req_addr[int'(gnt_idx)*ADDR_W +: ADDR_W];
          fsm_d  = F_CHECK;
        end
      end
      F_CHECK: begin
        iaddr_d = addr_q;
        kind_d  = 1'b0;
        evict_d = 1'b0;
        if (!tag_hit) begin
          pend_d  = e_vec;
          iaddr_d = {e_tag, addr_q[IDX_W-1:0]};
          evict_d = 1'b1;
        end else if (wr_q) begin
          pend_d = h_vec & ~cur_oh;
        end else if (h_st == LS_MOD && h_vec != cur_oh) begin
          pend_d = h_vec;
          kind_d = 1'b1;
        end else begin
          pend_d = '0;
        end
        fsm_d = (pend_d != '0) ? F_WAIT : F_DONE;
      end
      F_WAIT: begin
        pend_d = pend_q & ~inv_ack;
        if (pend_d == '0) begin
          if (evict_q) begin
            tbl_we = 1'b1;
            fsm_d  = F_CHECK;
          end else begin
            fsm_d  = F_DONE;
          end
        end
      end
      F_DONE: begin
        tbl_we = 1'b1;
        if (wr_q) begin
          w_st  = LS_MOD;
          w_vec = cur_oh;
        end else if (h_st == LS_MOD && h_vec == cur_oh) begin
          w_st  = LS_MOD;
          w_vec = h_vec;
        end else begin
          w_st  = LS_SHR;
          w_vec = h_vec | cur_oh;
        end
        fsm_d = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  // registers with explicit enables
  logic lat_en, chk_en;
  assign lat_en = take;
  assign chk_en = (fsm_q == F_CHECK);

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      fsm_q   <= F_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      kind_q  <= 1'b0;
      iaddr_q <= '0;
      evict_q <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      pend_q <= pend_d;
      if (lat_en) begin
        cur_q  <= cur_d;
        wr_q   <= wr_d;
        addr_q <= addr_d;
      end
      if (chk_en) begin
        kind_q  <= kind_d;
        iaddr_q <= iaddr_d;
        evict_q <= evict_d;
      end
    end
  end

  assign resp_valid = (fsm_q == F_DONE) ? cur_oh : '0;
  assign resp_excl  = (fsm_q == F_DONE) && wr_q;
  assign inv_valid  = (fsm_q == F_WAIT) ? pend_q : '0;
  assign inv_kind   = kind_q;
  assign inv_addr   = iaddr_q;
endmodule

// File: rtl/dir_checker.sv
module dir_checker #(
  parameter int NCORE  = 6,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORE-1:0]  req_valid,
  input logic [NCORE-1:0]  resp_valid,
  input logic              resp_excl,
  input logic [NCORE-1:0]  inv_valid,
  input logic [ADDR_W-1:0] inv_addr,
  input logic [NCORE-1:0]  inv_ack
);
  assert_resp_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp_valid));

  assert_resp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid != '0) |=> (resp_valid == '0));

  assert_excl_with_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_excl |-> (resp_valid != '0));

  assert_resp_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid != '0) |-> ($past(inv_valid & ~inv_ack) == '0));

  assert_inv_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((inv_valid != '0) && ($past(inv_valid) != '0)) |-> $stable(inv_addr));

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assert_inv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid[c] && !inv_ack[c]) |=> inv_valid[c]);
    assert_inv_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid[c] && inv_ack[c]) |=> !inv_valid[c]);
    assert_resp_requested_R11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid[c] |-> $past(req_valid[c]));
  end
endmodule

bind dir_coherence dir_checker #(.NCORE(NCORE), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .resp_valid(resp_valid),
  .resp_excl(resp_excl), .inv_valid(inv_valid), .inv_addr(inv_addr),
  .inv_ack(inv_ack)
);

// File: tb/sim_dir_coherence.sv
`timescale 1ns/1ps
module sim_dir_coherence;
  localparam int NC = 6;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] req_valid = '0;
  logic [NC-1:0] req_write = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC-1:0] resp_valid;
  logic          resp_excl;
  logic [NC-1:0] inv_valid;
  logic          inv_kind;
  logic [AW-1:0] inv_addr;
  logic [NC-1:0] inv_ack = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic          ack_hold = 1'b0;
  logic          clr_seen = 1'b0;
  logic [NC-1:0] seen_mask = '0;
  logic          seen_kind = 1'b0;
  logic [AW-1:0] seen_addr = '0;

  always #2 clk = ~clk;

  dir_coherence #(.NCORE(NC), .ADDR_W(AW), .SETS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_excl(resp_excl),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_addr(inv_addr),
    .inv_ack(inv_ack)
  );

  // model cores: acknowledge one cycle after an invalidate appears
  always @(negedge clk) begin
    for (int c = 0; c < NC; c++)
      inv_ack[c] <= inv_valid[c] && !inv_ack[c] && !ack_hold;
    seen_mask <= (clr_seen ? '0 : seen_mask) | inv_valid;
    if (inv_valid != '0) begin
      seen_kind <= inv_kind;
      seen_addr <= inv_addr;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_seen();
    @(posedge clk); clr_seen = 1'b1;
    @(posedge clk); clr_seen = 1'b0;
  endtask

  task automatic post(input int c, input bit wr, input logic [AW-1:0] a);
    req_addr[c*AW +: AW] = a;
    req_write[c] = wr;
    req_valid[c] = 1'b1;
  endtask

  // wait for n completions, recording order and exclusivity
  int  ord  [4];
  bit  exl  [4];
  task automatic collect(input int n);
    int got = 0;
    for (int t = 0; t < 300 && got < n; t++) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        if (resp_valid[c]) begin
          ord[got] = c;
          exl[got] = resp_excl;
          got++;
          req_valid[c] = 1'b0;
        end
      end
    end
    if (got < n) chk(1'b0, "R11 response timeout", got, n);
  endtask

  // {core[35:33], wr[32], addr[31:20], excl[19], mask[18:13], kind[12], iaddr[11:0]}
  localparam logic [35:0] VEC [10] = '{
    {3'd0, 1'b0, 12'h010, 1'b0, 6'b000000, 1'b0, 12'h000}, // R2
    {3'd1, 1'b0, 12'h010, 1'b0, 6'b000000, 1'b0, 12'h000}, // R2
    {3'd2, 1'b0, 12'h010, 1'b0, 6'b000000, 1'b0, 12'h000}, // R2
    {3'd1, 1'b1, 12'h010, 1'b1, 6'b000101, 1'b0, 12'h010}, // R3 R4
    {3'd1, 1'b1, 12'h010, 1'b1, 6'b000000, 1'b0, 12'h000}, // R6
    {3'd3, 1'b0, 12'h010, 1'b0, 6'b000010, 1'b1, 12'h010}, // R5
    {3'd4, 1'b1, 12'h010, 1'b1, 6'b001010, 1'b0, 12'h010}, // R5 R3
    {3'd5, 1'b0, 12'h018, 1'b0, 6'b010000, 1'b0, 12'h010}, // R9
    {3'd0, 1'b1, 12'h021, 1'b1, 6'b000000, 1'b0, 12'h000}, // R4
    {3'd2, 1'b0, 12'h021, 1'b0, 6'b000001, 1'b1, 12'h021}  // R5
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet while in reset and just after release
    chk(resp_valid == '0 && inv_valid == '0, "R1 reset outputs", {resp_valid, inv_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(resp_valid == '0 && inv_valid == '0, "R1 idle after reset", {resp_valid, inv_valid}, 0);

    for (int i = 0; i < 10; i++) begin
      logic [35:0] v;
      int c;
      v = VEC[i];
      c = int'(v[35:33]);
      clear_seen();
      @(negedge clk);
      post(c, v[32], v[31:20]);
      collect(1);
      chk(ord[0] == c, $sformatf("R11 vec %0d responder", i), ord[0], c);
      chk(exl[0] == v[19], $sformatf("R4 vec %0d excl", i), exl[0], v[19]);
      chk(seen_mask == v[18:13], $sformatf("R3 R5 R9 vec %0d inv targets", i), seen_mask, v[18:13]);
      if (v[18:13] != '0) begin
        chk(seen_kind == v[12], $sformatf("R5 vec %0d inv kind", i), seen_kind, v[12]);
        chk(seen_addr == v[11:0], $sformatf("R9 R10 vec %0d inv addr", i), seen_addr, v[11:0]);
      end
    end

    // R7: core1 write needs core5 invalidated; acks frozen, core0 waits behind it
    ack_hold = 1'b1;
    clear_seen();
    @(negedge clk);
    post(1, 1'b1, 12'h018);
    repeat (4) @(negedge clk);
    post(0, 1'b0, 12'h021);
    begin
      bit quiet = 1'b1;
      for (int t = 0; t < 12; t++) begin
        @(negedge clk);
        if (resp_valid != '0) quiet = 1'b0;
      end
      chk(quiet, "R7 no response while acks pending", quiet, 1);
      chk(inv_valid == 6'b100000, "R10 invalidate held without ack", inv_valid, 6'b100000);
    end
    ack_hold = 1'b0;
    collect(2);
    chk(ord[0] == 1 && exl[0], "R7 stalled write completes first", ord[0], 1);
    chk(ord[1] == 0 && !exl[1], "R7 waiting read served next", ord[1], 0);

    // R8: last served core0 -> cores 1 and 3 together: 1 then 3
    @(negedge clk);
    post(1, 1'b0, 12'h002);
    post(3, 1'b0, 12'h003);
    collect(2);
    chk(ord[0] == 1 && ord[1] == 3, "R8 order after core0", {ord[0][7:0], ord[1][7:0]}, 16'h0103);
    // last served core3 -> cores 1 and 5 together: 5 wraps ahead of 1
    @(negedge clk);
    post(1, 1'b0, 12'h002);
    post(5, 1'b0, 12'h004);
    collect(2);
    chk(ord[0] == 5 && ord[1] == 1, "R8 order after core3", {ord[0][7:0], ord[1][7:0]}, 16'h0501);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule